// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether an I2C slave is being addressed. The bit-level receiver hands it each received byte with a one-cycle valid strobe. It also supplies a flag that marks the first byte after a START condition and a flag that says whether that START was a repeated START. The block compares the first byte against a stored own-address value and raises a registered addressed flag on a match. In both addressing formats it records the direction bit of that byte.

In 7-bit format only the upper address bits take part in the compare, and the direction bit is ignored. In 10-bit format every bit of the first byte takes part, including the direction bit. After a match, the block raises a pending indication, because the second address byte is left for software to check. When software has confirmed both bytes, it pulses a set input that arms a read-compare bit. The next first byte after a repeated START is then matched against the upper register bits with a forced direction of 1. A STOP condition clears the addressed flag, the pending indication and the read-compare bit.

Top module: `i2c_addr_match`

## Requirements
- R1: After a synchronous reset, `aas`, `dir`, `sec_pend` and `rd_armed` are all 0.
- R2: In 7-bit mode (`mode10`=0), a first byte whose bits [W-1:1] equal `own_addr[W-1:1]` sets `aas` on the following cycle, whatever the value of bit 0.
- R3: Any first byte that does not match clears `aas` and `sec_pend` on the following cycle, in either mode.
- R4: In 10-bit mode, a first byte after a plain START matches only if all W bits equal `own_addr`. A match sets both `aas` and `sec_pend`.
- R5: On every first byte, `dir` takes bit 0 of that byte on the following cycle.
- R6: A valid byte that is not a first byte clears `sec_pend` and leaves `aas` and `dir` unchanged.
- R7: A one-cycle pulse on `rd_set` sets `rd_armed`. While `rd_armed` is 1 in 10-bit mode, a first byte flagged as a repeated START is compared against {`own_addr[W-1:1]`, 1'b1}. A match sets `aas` and leaves `sec_pend` at 0.
- R8: A `stop` pulse clears `aas`, `sec_pend` and `rd_armed` on the following cycle. It takes priority over a byte or an `rd_set` pulse in the same cycle.
- R9: `rd_armed` has no effect on a first byte that is not flagged as a repeated START. Such a byte is compared against the full `own_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | W | Received byte, bit 0 is the direction bit |
| first_byte | input | 1 | The strobed byte is the first byte after a START |
| rep_start | input | 1 | That START was a repeated START |
| stop | input | 1 | One-cycle STOP condition pulse |
| mode10 | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_addr | input | W | Stored slave address register |
| rd_set | input | 1 | Software pulse that arms the read compare |
| aas | output | 1 | Addressed-as-slave flag |
| dir | output | 1 | Direction bit of the latest first byte |
| sec_pend | output | 1 | Second 10-bit address byte awaits software compare |
| rd_armed | output | 1 | Read-compare bit state |

## Verification
The bench builds the block with W=4, so the address has three upper bits and one direction bit. This makes a full sweep feasible: every register value is crossed with every received byte in both modes, 512 combinations, each replayed as a plain START. For each pair that passes the 10-bit compare, the bench also runs the armed repeated-START compare over every byte value and the second-byte clearing path. This covers every match and mismatch pattern of the compare logic rather than a sample.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef struct packed {
    logic hit;
    logic pend;
  } am_dec_t;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] rx,
  input  logic [W-1:0] own,
  input  logic         mode10,
  input  logic         rep_start,
  input  logic         armed,
  output am_dec_t      dec
);
  localparam int UW = W - 1;

  logic         rd_path;
  logic         lsb_ref;
  logic [UW-1:0] up_rx;
  logic [UW-1:0] up_own;

  assign up_rx   = rx[W-1:1];
  assign up_own  = own[W-1:1];
  assign rd_path = mode10 && rep_start && armed;
  assign lsb_ref = rd_path ? 1'b1 : own[0];

  always_comb begin
    dec = '0;
    if (!mode10) begin
      dec.hit = (up_rx == up_own);
    end else begin
      dec.hit  = (up_rx == up_own) && (rx[0] == lsb_ref);
      dec.pend = dec.hit && !rd_path;
    end
  end
endmodule

// File: rtl/i2c_am_regs.sv
module i2c_am_regs
  import i2c_am_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    byte_vld,
  input  logic    first_byte,
  input  logic    dir_bit,
  input  logic    stop,
  input  logic    rd_set,
  input  am_dec_t dec,
  output logic    aas,
  output logic    dir,
  output logic    sec_pend,
  output logic    rd_armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      aas      <= 1'b0;
      dir      <= 1'b0;
      sec_pend <= 1'b0;
      rd_armed <= 1'b0;
    end else if (stop) begin
      aas      <= 1'b0;
      sec_pend <= 1'b0;
      rd_armed <= 1'b0;
    end else begin
      if (rd_set) rd_armed <= 1'b1;
      if (byte_vld) begin
        if (first_byte) begin
          aas      <= dec.hit;
          sec_pend <= dec.pend;
          dir      <= dir_bit;
        end else begin
          sec_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         byte_vld,
  input  logic [W-1:0] rx_byte,
  input  logic         first_byte,
  input  logic         rep_start,
  input  logic         stop,
  input  logic         mode10,
  input  logic [W-1:0] own_addr,
  input  logic         rd_set,
  output logic         aas,
  output logic         dir,
  output logic         sec_pend,
  output logic         rd_armed
);
  am_dec_t dec;

  i2c_am_cmp #(.W(W)) u_cmp (
    .rx        (rx_byte),
    .own       (own_addr),
    .mode10    (mode10),
    .rep_start (rep_start),
    .armed     (rd_armed),
    .dec       (dec)
  );

  i2c_am_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .first_byte (first_byte),
    .dir_bit    (rx_byte[0]),
    .stop       (stop),
    .rd_set     (rd_set),
    .dec        (dec),
    .aas        (aas),
    .dir        (dir),
    .sec_pend   (sec_pend),
    .rd_armed   (rd_armed)
  );
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         byte_vld,
  input logic [W-1:0] rx_byte,
  input logic         first_byte,
  input logic         rep_start,
  input logic         stop,
  input logic         mode10,
  input logic [W-1:0] own_addr,
  input logic         rd_set,
  input logic         aas,
  input logic         dir,
  input logic         sec_pend,
  input logic         rd_armed
);
  logic fb;
  assign fb = byte_vld && first_byte && !stop;

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!aas && !sec_pend && !rd_armed)); // R8

  AST_MATCH7: assert property (@(posedge clk) disable iff (rst)
    (fb && !mode10 && rx_byte[W-1:1] == own_addr[W-1:1]) |=> aas); // R2

  AST_MISS7: assert property (@(posedge clk) disable iff (rst)
    (fb && !mode10 && rx_byte[W-1:1] != own_addr[W-1:1]) |=> (!aas && !sec_pend)); // R3

  AST_DIR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    fb |=> (dir == $past(rx_byte[0]))); // R5

  AST_PEND_NEEDS_AAS: assert property (@(posedge clk) disable iff (rst)
    sec_pend |-> aas); // R4

  AST_DATA_KEEPS_AAS: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !first_byte && !stop) |=> ($stable(aas) && !sec_pend)); // R6

  AST_ARM_SET: assert property (@(posedge clk) disable iff (rst)
    (rd_set && !stop) |=> rd_armed); // R7
endmodule

bind i2c_addr_match i2c_am_chk #(.W(W)) u_chk (.*);

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         byte_vld = 1'b0;
  logic [W-1:0] rx_byte = '0;
  logic         first_byte = 1'b0;
  logic         rep_start = 1'b0;
  logic         stop = 1'b0;
  logic         mode10 = 1'b0;
  logic [W-1:0] own_addr = '0;
  logic         rd_set = 1'b0;
  logic         aas, dir, sec_pend, rd_armed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_match #(.W(W)) u_i2c_addr_match (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s own=%0d rx=%0d m10=%0b act=%0b exp=%0b",
               req, own_addr, rx_byte, mode10, act, exp);
    end
  endtask

  // drive one cycle of stimulus, return at the negedge after the capturing edge
  task automatic pulse(input logic v, input logic [W-1:0] b, input logic fst,
                       input logic rs, input logic sp, input logic rset);
    @(negedge clk);
    byte_vld = v; rx_byte = b; first_byte = fst; rep_start = rs; stop = sp; rd_set = rset;
    @(negedge clk);
    byte_vld = 0; first_byte = 0; rep_start = 0; stop = 0; rd_set = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 aas", aas, 1'b0);
    chk("R1 dir", dir, 1'b0);
    chk("R1 sec_pend", sec_pend, 1'b0);
    chk("R1 rd_armed", rd_armed, 1'b0);

    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < N; o++) begin
        for (int r = 0; r < N; r++) begin
          logic hit;
          mode10 = m[0];
          own_addr = o[W-1:0];
          pulse(0, '0, 0, 0, 1, 0);
          chk("R8 stop clears aas", aas, 1'b0);
          pulse(1, r[W-1:0], 1, 0, 0, 0);
          hit = m ? (r == o) : ((r >> 1) == (o >> 1));
          chk(m ? "R4 aas" : (hit ? "R2 aas" : "R3 aas"), aas, hit);
          chk(m ? "R4 sec_pend" : "R3 sec_pend", sec_pend, m[0] && hit);
          chk("R5 dir", dir, r[0]);
          if (m == 1 && hit) begin
            // data byte: clears pending, aas and dir held
            pulse(1, ~r[W-1:0], 0, 0, 0, 0);
            chk("R6 sec_pend", sec_pend, 1'b0);
            chk("R6 aas", aas, 1'b1);
            chk("R6 dir", dir, r[0]);
            pulse(0, '0, 0, 0, 0, 1);
            chk("R7 rd_armed", rd_armed, 1'b1);
            // plain START with armed bit: full compare to own_addr
            pulse(1, r[W-1:0] | 1, 1, 0, 0, 0);
            chk("R9 armed plain start", aas, ((r | 1) == o));
            for (int q = 0; q < N; q++) begin
              pulse(1, q[W-1:0], 1, 1, 0, 0);
              chk("R7 restart aas", aas, (q == (o | 1)));
              chk("R7 restart pend", sec_pend, 1'b0);
            end
            pulse(1, r[W-1:0], 1, 0, 1, 1);
            chk("R8 stop priority aas", aas, 1'b0);
            chk("R8 stop clears rd_armed", rd_armed, 1'b0);
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule